// File: doc/BRIEF.md
# Byte-Serial DMA Channel Register Bank

This block holds the programming registers of four DMA channels behind an 8-bit host port. Each channel keeps a 16-bit base address, a 16-bit base count, a current address, a progress count and a direction bit. All 16-bit quantities move across the port one byte at a time. A single byte-pointer flip-flop, shared by every channel, picks which byte each access touches and flips after every accepted access. Software therefore always sends or fetches the low byte first and the high byte second, after it has cleared the pointer.

The host presents a port number. The block shifts it right by the word-mode shift `WSHIFT` and keeps four bits of the result as a register index. `WSHIFT` is 0 for a controller with 8-bit transfers and 1 for one with 16-bit transfers. Reads do not return the stored registers. The block computes a live address from the current address and the progress count, taking the direction bit into account, and a remaining count from the base count and the progress count. A transfer agent outside the block reports progress for each channel through a dedicated input.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset the byte pointer is 0, and every base, current, progress and direction register is 0. Every read of index 0..7 then returns 0x00.
- R2: The register index is (host_port >> WSHIFT) masked to 4 bits. Index bits [2:1] give the channel and index bit 0 picks address (0) or count (1). An index of 8 or more is ignored: a read returns 0x00, a write changes nothing, and the byte pointer holds its value.
- R3: Each read or write to index 0..7 uses the current byte pointer and then inverts it. Pointer 0 means the low byte and pointer 1 means the high byte. While no such access is made, the pointer keeps its value.
- R4: A write with pointer 0 replaces bits [7:0] of the selected base register. A write with pointer 1 replaces bits [15:8].
- R5: A high-byte write to either register of a channel loads that channel's current address with its base address (the newly written value included) shifted left by WSHIFT. The same write clears the channel's progress count. A low-byte write leaves the current address and the progress count as they were.
- R6: An address read computes current address + progress when the channel's direction bit is 0, and current address − progress when it is 1. The result is taken modulo 2^(16+WSHIFT).
- R7: A count read computes (base count << WSHIFT) − progress, modulo 2^(16+WSHIFT).
- R8: The returned byte is bits [WSHIFT+8·p+7 : WSHIFT+8·p] of the computed value, where p is the pointer before the access.
- R9: While ff_clear is high, the pointer is 0 on the next cycle. This takes priority over an access made in the same cycle.
- R10: A pulse on prog_we loads prog_value into the progress count of channel prog_chan. Reads from the next cycle on reflect the new value. If a high-byte host write to the same channel falls in the same cycle, the host write wins.
- R11: A pulse on mode_we loads mode_down into the direction bit of channel mode_chan. No other channel is affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_port | input | 4+WSHIFT | Host port number |
| host_wr | input | 1 | Host write strobe, one byte per cycle |
| host_rd | input | 1 | Host read strobe, one byte per cycle |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Readback byte for the indexed register and current pointer |
| ff_clear | input | 1 | Forces the byte pointer to 0 |
| mode_we | input | 1 | Direction bit write strobe |
| mode_chan | input | 2 | Channel whose direction bit is written |
| mode_down | input | 1 | New direction: 1 = address counts down |
| prog_we | input | 1 | Progress count write strobe |
| prog_chan | input | 2 | Channel whose progress count is written |
| prog_value | input | 16+WSHIFT | New progress count |

## Verification
A wrong pointer value shows up on the very next read as swapped bytes. That makes a missed or extra toggle visible after one access, and an ignored index is caught by reading a valid register immediately afterwards. A missing or premature reload corrupts the address readback only once progress is nonzero, so the sweep sets progress after every reload and then reads both bytes of both registers. A wrong direction bit or wrong shift alignment changes the high byte whenever the sum borrows or carries across bit 8+WSHIFT, and the progress values are chosen so that this happens.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  localparam int unsigned NUM_CH = 4;
  localparam int unsigned IDX_W  = 4;
  localparam int unsigned CH_W   = 2;

  typedef enum logic {
    SEL_ADDR = 1'b0,
    SEL_CNT  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/dbr_byte_pointer.sv
module dbr_byte_pointer (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic clear,
  output logic ptr_q
);
  logic ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (clear)     ptr_d = 1'b0;
    else if (step) ptr_d = ~ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= 1'b0;
    else        ptr_q <= ptr_d;
  end
endmodule

// File: rtl/dbr_chan.sv
module dbr_chan
  import dbr_pkg::*;
#(
  parameter int unsigned WSHIFT = 0,
  parameter int unsigned VAL_W  = 16 + WSHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_sel_e         wr_sel,
  input  logic             wr_hi,
  input  logic [7:0]       wdata,
  input  logic             dir_we,
  input  logic             dir_in,
  input  logic             prog_we,
  input  logic [VAL_W-1:0] prog_in,
  output logic [15:0]      base_cnt_q,
  output logic [VAL_W-1:0] cur_addr_q,
  output logic [VAL_W-1:0] prog_q,
  output logic             dir_q
);
  logic [15:0]      base_addr_q, base_addr_d, base_cnt_d;
  logic [VAL_W-1:0] cur_addr_d, prog_d;
  logic             dir_d;
  logic             en;

  always_comb begin
    base_addr_d = base_addr_q;
    base_cnt_d  = base_cnt_q;
    cur_addr_d  = cur_addr_q;
    prog_d      = prog_q;
    dir_d       = dir_q;
    if (dir_we)  dir_d  = dir_in;
    if (prog_we) prog_d = prog_in;
    if (wr_en) begin
      if (!wr_hi) begin
        if (wr_sel == SEL_ADDR) base_addr_d[7:0] = wdata;
        else                    base_cnt_d[7:0]  = wdata;
      end else begin
        if (wr_sel == SEL_ADDR) base_addr_d[15:8] = wdata;
        else                    base_cnt_d[15:8]  = wdata;
        // high byte completes the pair: reload, host write beats progress
        cur_addr_d = VAL_W'(base_addr_d) << WSHIFT;
        prog_d     = '0;
      end
    end
  end

  assign en = wr_en | dir_we | prog_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      cur_addr_q  <= '0;
      prog_q      <= '0;
      dir_q       <= 1'b0;
    end else if (en) begin
      base_addr_q <= base_addr_d;
      base_cnt_q  <= base_cnt_d;
      cur_addr_q  <= cur_addr_d;
      prog_q      <= prog_d;
      dir_q       <= dir_d;
    end
  end
endmodule

// File: rtl/dbr_readback.sv
module dbr_readback
  import dbr_pkg::*;
#(
  parameter int unsigned WSHIFT = 0,
  parameter int unsigned VAL_W  = 16 + WSHIFT
) (
  input  logic             valid,
  input  reg_sel_e         sel,
  input  logic             ptr,
  input  logic [15:0]      base_cnt,
  input  logic [VAL_W-1:0] cur_addr,
  input  logic [VAL_W-1:0] prog,
  input  logic             dir,
  output logic [7:0]       rb_byte
);
  logic [VAL_W-1:0] live_addr, remain, val, shifted;

  always_comb begin
    live_addr = dir ? (cur_addr - prog) : (cur_addr + prog);
    remain    = (VAL_W'(base_cnt) << WSHIFT) - prog;
    val       = (sel == SEL_CNT) ? remain : live_addr;
    shifted   = val >> (WSHIFT + (ptr ? 8 : 0));
    rb_byte   = valid ? shifted[7:0] : 8'h00;
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dbr_pkg::*;
#(
  parameter int unsigned WSHIFT = 0,
  localparam int unsigned PORT_W = IDX_W + WSHIFT,
  localparam int unsigned VAL_W  = 16 + WSHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] host_port,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic              ff_clear,
  input  logic              mode_we,
  input  logic [CH_W-1:0]   mode_chan,
  input  logic              mode_down,
  input  logic              prog_we,
  input  logic [CH_W-1:0]   prog_chan,
  input  logic [VAL_W-1:0]  prog_value
);
  logic [IDX_W-1:0] idx;
  logic             in_range;
  logic [CH_W-1:0]  chan;
  reg_sel_e         sel;
  logic             access;
  logic             byte_ptr;

  logic [15:0]      base_cnt_v [NUM_CH];
  logic [VAL_W-1:0] cur_addr_v [NUM_CH];
  logic [VAL_W-1:0] prog_v     [NUM_CH];
  logic             dir_v      [NUM_CH];

  assign idx      = host_port[WSHIFT +: IDX_W];
  assign in_range = ~idx[IDX_W-1];
  assign chan     = idx[CH_W:1];
  assign sel      = reg_sel_e'(idx[0]);
  assign access   = (host_wr | host_rd) & in_range;

  dbr_byte_pointer u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (access),
    .clear (ff_clear),
    .ptr_q (byte_ptr)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dbr_chan #(.WSHIFT(WSHIFT), .VAL_W(VAL_W)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (host_wr & in_range & (chan == CH_W'(c))),
      .wr_sel     (sel),
      .wr_hi      (byte_ptr),
      .wdata      (host_wdata),
      .dir_we     (mode_we & (mode_chan == CH_W'(c))),
      .dir_in     (mode_down),
      .prog_we    (prog_we & (prog_chan == CH_W'(c))),
      .prog_in    (prog_value),
      .base_cnt_q (base_cnt_v[c]),
      .cur_addr_q (cur_addr_v[c]),
      .prog_q     (prog_v[c]),
      .dir_q      (dir_v[c])
    );
  end

  dbr_readback #(.WSHIFT(WSHIFT), .VAL_W(VAL_W)) u_rb (
    .valid    (in_range),
    .sel      (sel),
    .ptr      (byte_ptr),
    .base_cnt (base_cnt_v[chan]),
    .cur_addr (cur_addr_v[chan]),
    .prog     (prog_v[chan]),
    .dir      (dir_v[chan]),
    .rb_byte  (host_rdata)
  );
endmodule

// File: rtl/dbr_checker.sv
module dbr_checker #(
  parameter int unsigned WSHIFT = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3+WSHIFT:0] host_port,
  input logic              host_wr,
  input logic              host_rd,
  input logic              ff_clear,
  input logic [7:0]        host_rdata,
  input logic              ptr
);
  logic hit;
  assign hit = (host_wr | host_rd) & (host_port[3+WSHIFT] == 1'b0);

  assert_ptr_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !ff_clear) |=> (ptr != $past(ptr)));

  assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !ff_clear) |=> $stable(ptr));

  assert_ptr_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ff_clear |=> !ptr);

  assert_ignored_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_port[3+WSHIFT]) |-> (host_rdata == 8'h00));
endmodule

bind dma_chan_regs dbr_checker #(.WSHIFT(WSHIFT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_port  (host_port),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .ff_clear   (ff_clear),
  .host_rdata (host_rdata),
  .ptr        (byte_ptr)
);

// File: tb/sim_dma_chan_regs.sv
module sim_dma_chan_regs;
  localparam int SH = 1;
  localparam int VW = 16 + SH;
  localparam int VMASK = (1 << VW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4+SH-1:0] host_port = '0;
  logic          host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0]    host_wdata = '0;
  logic [7:0]    host_rdata;
  logic          ff_clear = 1'b0;
  logic          mode_we = 1'b0, mode_down = 1'b0;
  logic [1:0]    mode_chan = '0, prog_chan = '0;
  logic          prog_we = 1'b0;
  logic [VW-1:0] prog_value = '0;

  int checks = 0, errors = 0;
  int m_ba [4], m_bc [4], m_ca [4], m_pg [4], m_dn [4];
  int m_ff = 0;

  always #4 clk = ~clk;

  dma_chan_regs #(.WSHIFT(SH)) u0 (.*);

  function automatic int exp_byte(int idx);
    int ch, val;
    if (idx >= 8) return 0;
    ch = idx >> 1;
    if (idx & 1) val = (m_bc[ch] << SH) - m_pg[ch];
    else val = m_dn[ch] ? m_ca[ch] - m_pg[ch] : m_ca[ch] + m_pg[ch];
    val &= VMASK;
    return (val >> (SH + 8 * m_ff)) & 255;
  endfunction

  task automatic rd_chk(int idx, string req);
    int e;
    @(negedge clk);
    host_port = (4 + SH)'(idx << SH);
    host_rd = 1'b1;
    #2;
    e = exp_byte(idx);
    checks++;
    if (host_rdata !== 8'(e)) begin
      errors++;
      $display("FAIL %s idx %0d: got %02h expected %02h", req, idx, host_rdata, e);
    end
    @(posedge clk); #1;
    host_rd = 1'b0;
    if (idx < 8) m_ff ^= 1;
  endtask

  task automatic wr(int idx, int data);
    int ch;
    @(negedge clk);
    host_port = (4 + SH)'(idx << SH);
    host_wdata = 8'(data);
    host_wr = 1'b1;
    @(posedge clk); #1;
    host_wr = 1'b0;
    if (idx < 8) begin
      ch = idx >> 1;
      if (m_ff == 0) begin
        if (idx & 1) m_bc[ch] = (m_bc[ch] & 'hFF00) | (data & 255);
        else         m_ba[ch] = (m_ba[ch] & 'hFF00) | (data & 255);
      end else begin
        if (idx & 1) m_bc[ch] = (m_bc[ch] & 255) | ((data & 255) << 8);
        else         m_ba[ch] = (m_ba[ch] & 255) | ((data & 255) << 8);
        m_ca[ch] = (m_ba[ch] << SH) & VMASK;
        m_pg[ch] = 0;
      end
      m_ff ^= 1;
    end
  endtask

  task automatic clr_ff();
    @(negedge clk); ff_clear = 1'b1;
    @(posedge clk); #1; ff_clear = 1'b0;
    m_ff = 0;
  endtask

  task automatic set_prog(int ch, int v);
    @(negedge clk); prog_chan = 2'(ch); prog_value = VW'(v); prog_we = 1'b1;
    @(posedge clk); #1; prog_we = 1'b0;
    m_pg[ch] = v & VMASK;
  endtask

  task automatic set_dir(int ch, int d);
    @(negedge clk); mode_chan = 2'(ch); mode_down = d[0]; mode_we = 1'b1;
    @(posedge clk); #1; mode_we = 1'b0;
    m_dn[ch] = d & 1;
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int progs [4];
    for (int i = 0; i < 4; i++) begin
      m_ba[i] = 0; m_bc[i] = 0; m_ca[i] = 0; m_pg[i] = 0; m_dn[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, both bytes of every register
    for (int i = 0; i < 16; i++) rd_chk(i >> 1, "R1");

    // R2/R3: ignored index neither reads nor toggles the pointer
    clr_ff();
    wr(0, 'h34); wr(0, 'h12);
    rd_chk(9, "R2");
    rd_chk(0, "R2 R3 no toggle on ignored index");
    wr(12, 'hAA);
    rd_chk(0, "R2 ignored write");

    // R9: clear restores low-byte phase
    clr_ff();
    rd_chk(0, "R9");
    clr_ff();
    rd_chk(0, "R9 again");

    // Sweep R4 R5 R6 R7 R8 R10 R11
    progs[0] = 0; progs[1] = 1; progs[2] = 'h155; progs[3] = VMASK;
    for (int ch = 0; ch < 4; ch++) begin
      for (int pat = 0; pat < 4; pat++) begin
        int a, c;
        a = (ch * 'h3A71 + pat * 'h51C3 + 'h00F0) & 'hFFFF;
        c = (ch * 'h1234 + pat * 'h0FED + 'h0081) & 'hFFFF;
        clr_ff();
        set_dir(ch, pat & 1);
        wr(2 * ch, a & 255); wr(2 * ch, a >> 8);
        wr(2 * ch + 1, c & 255); wr(2 * ch + 1, c >> 8);
        for (int p = 0; p < 4; p++) begin
          set_prog(ch, progs[p] + pat);
          rd_chk(2 * ch, "R6 R8 R10");
          rd_chk(2 * ch, "R6 R8");
          rd_chk(2 * ch + 1, "R7 R8");
          rd_chk(2 * ch + 1, "R7 R4");
        end
      end
    end

    // R11: direction of channel 2 unaffected by channel 1
    set_dir(1, 1);
    set_prog(2, 'h300);
    clr_ff();
    rd_chk(4, "R11"); rd_chk(4, "R11");

    // R5: low-byte write does not reload, high-byte write does
    clr_ff();
    set_prog(3, 'h222);
    wr(6, 'h5A);
    rd_chk(6, "R5 low write keeps current");
    clr_ff();
    rd_chk(6, "R5 low write keeps current");
    rd_chk(6, "R5");
    wr(7, 'h11); wr(7, 'h22);
    clr_ff();
    rd_chk(6, "R5 reload via count high byte");
    rd_chk(6, "R5");

    // R10: host high-byte write beats same-cycle progress update
    clr_ff();
    wr(2, 'h10);
    @(negedge clk);
    host_port = (4 + SH)'(2 << SH); host_wdata = 8'h20; host_wr = 1'b1;
    prog_chan = 2'd1; prog_value = VW'('h777); prog_we = 1'b1;
    @(posedge clk); #1;
    host_wr = 1'b0; prog_we = 1'b0;
    m_ba[1] = 'h2010; m_ca[1] = ('h2010 << SH) & VMASK; m_pg[1] = 0; m_ff = 0;
    rd_chk(2, "R10 write priority"); rd_chk(3, "R10 write priority");

    summary();
    $finish;
  end
endmodule